// File: doc/BRIEF.md
# Shared-Bus Multicycle Core with Memory-to-Memory Add

This block is a small processor core in which every transfer between storage elements travels over one 32-bit bus. A microsequencer steps through a fixed set of microstates. In each state it enables at most one source onto the bus and any number of destinations that load from it. The datapath holds a program counter, two ALU operand latches (A and B), a memory address latch, an instruction latch and a one-bit zero flag. It also contains a sixteen-entry register file and a 1024-word memory.

The core fetches instructions and executes a read-modify-write add. That add reads the memory word addressed by one register, adds a second register to it, and writes the sum back to the same word. A halt opcode stops the sequencer so that final state can be examined. Every other opcode does nothing beyond the fetch.

Register and memory contents are loaded through a preload port while reset is held. They are read back through a combinational peek port.

Top module: `sbusCpu`

## Requirements
- R1: While `rstN` is low, `pc` is 0, `halted` is 0 and `zFlag` is 0. The first fetch starts on the first rising edge after release.
- R2: A fetch takes three cycles. The instruction word is taken from memory at the current PC, and `pc` increases by one on the third rising edge of the fetch. The opcode sits in bits 31..28.
- R3: Opcode 4'h5 is the memory add. The first source register index is in bits 27..24 and the address register index is in bits 23..20. The instruction spends four execute cycles after its fetch, seven cycles in all. On its seventh edge, memory at the address register's value receives that word plus the first source register.
- R4: `zFlag` loads on the seventh edge of a memory add: it becomes 1 when the stored sum is zero and 0 otherwise. It holds its value at every other edge.
- R5: Register index 0 always reads as zero. A preload to index 0 has no effect.
- R6: Memory is addressed by the low 10 bits of the address value; higher bits are ignored.
- R7: Opcode 4'hF halts the core. `halted` rises on the third edge of its fetch, and from then on `pc` and memory no longer change.
- R8: Any opcode other than 4'h5 and 4'hF completes in its three fetch cycles and changes nothing but `pc`.
- R9: At most one bus source is enabled in any cycle. The ALU functions are 00 add, 01 NAND, 10 subtract A minus B, and 11 increment A.
- R10: The preload port writes storage only while `rstN` is low. A preload strobe while running leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset; preload window |
| progWe | input | 1 | Preload write strobe (honoured only in reset) |
| progToReg | input | 1 | 1 = preload targets register file, 0 = memory |
| progAddr | input | 10 | Preload word or register index |
| progData | input | 32 | Preload data |
| peekToReg | input | 1 | 1 = peek reads register file, 0 = memory |
| peekAddr | input | 10 | Peek word or register index |
| peekData | output | 32 | Combinational peek result |
| pc | output | 32 | Current program counter |
| zFlag | output | 1 | Zero flag |
| halted | output | 1 | High once the halt opcode has been fetched |

## Verification
Each instruction's effects are due on fixed edges counted from its first fetch cycle. `pc` moves on the third edge, and `halted` rises on the third edge of a halt fetch. Memory and `zFlag` change on the seventh edge of a memory add. The bench advances a behavioural per-instruction step counter on every rising edge and applies each effect on exactly that edge. It compares `pc`, `halted` and `zFlag` on the following falling edge, so a result arriving one cycle early or late shows up as a mismatch. Final memory and register contents are read through the peek port after the halt.

// File: rtl/sbusPkg.sv
package sbusPkg;

  localparam int DATA_W    = 32;
  localparam int REG_CNT   = 16;
  localparam int MEM_DEPTH = 1024;

  localparam logic [3:0] OP_ADDM = 4'h5;
  localparam logic [3:0] OP_HALT = 4'hF;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_NAND = 2'b01,
    ALU_SUB  = 2'b10,
    ALU_INC  = 2'b11
  } aluFnT;

  typedef enum logic [1:0] {
    SEL_RX = 2'b00,
    SEL_RY = 2'b01,
    SEL_RZ = 2'b10
  } regSelT;

  typedef struct packed {
    logic   drPc;
    logic   drAlu;
    logic   drReg;
    logic   drMem;
    logic   drOff;
    logic   ldPc;
    logic   ldA;
    logic   ldB;
    logic   ldMar;
    logic   ldIr;
    logic   ldZ;
    logic   wrReg;
    logic   wrMem;
    regSelT regSel;
    aluFnT  aluFn;
  } ctrlT;

  typedef enum logic [2:0] {
    S_F0, S_F1, S_F2, S_M0, S_M1, S_M2, S_M3, S_HALT
  } stateT;

endpackage

// File: rtl/sbusAlu.sv
module sbusAlu
  import sbusPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluFnT             fn,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  output logic [WIDTH-1:0]  result
);

  always_comb begin
    case (fn)
      ALU_ADD:  result = opA + opB;
      ALU_NAND: result = ~(opA & opB);
      ALU_SUB:  result = opA - opB;
      default:  result = opA + WIDTH'(1);
    endcase
  end

endmodule

// File: rtl/sbusRegFile.sv
module sbusRegFile #(
  parameter int WIDTH = 32,
  parameter int COUNT = 16,
  localparam int AW   = $clog2(COUNT)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wAddr,
  input  logic [WIDTH-1:0] wData,
  input  logic [AW-1:0]    rAddr,
  output logic [WIDTH-1:0] rData,
  input  logic [AW-1:0]    pAddr,
  output logic [WIDTH-1:0] pData
);

  // Index 0 has no storage; it reads as zero and swallows writes.
  logic [WIDTH-1:0] regs [1:COUNT-1];

  for (genvar gi = 1; gi < COUNT; gi++) begin : gReg
    always_ff @(posedge clk) begin
      if (we && wAddr == AW'(gi)) regs[gi] <= wData;
    end
  end

  always_comb begin
    rData = '0;
    pData = '0;
    for (int k = 1; k < COUNT; k++) begin
      if (rAddr == AW'(k)) rData = regs[k];
      if (pAddr == AW'(k)) pData = regs[k];
    end
  end

endmodule

// File: rtl/sbusControl.sv
module sbusControl
  import sbusPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] opcode,
  output ctrlT       ctl,
  output logic       halted
);

  stateT state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_F0;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      S_F0: begin                  // MAR <- PC, A <- PC
        ctl.drPc  = 1'b1;
        ctl.ldMar = 1'b1;
        ctl.ldA   = 1'b1;
        nextState = S_F1;
      end
      S_F1: begin                  // IR <- MEM[MAR]
        ctl.drMem = 1'b1;
        ctl.ldIr  = 1'b1;
        nextState = S_F2;
      end
      S_F2: begin                  // PC <- A + 1, dispatch
        ctl.aluFn = ALU_INC;
        ctl.drAlu = 1'b1;
        ctl.ldPc  = 1'b1;
        case (opcode)
          OP_ADDM: nextState = S_M0;
          OP_HALT: nextState = S_HALT;
          default: nextState = S_F0;
        endcase
      end
      S_M0: begin                  // MAR <- Ry
        ctl.regSel = SEL_RY;
        ctl.drReg  = 1'b1;
        ctl.ldMar  = 1'b1;
        nextState  = S_M1;
      end
      S_M1: begin                  // A <- MEM[MAR]
        ctl.drMem = 1'b1;
        ctl.ldA   = 1'b1;
        nextState = S_M2;
      end
      S_M2: begin                  // B <- Rx
        ctl.regSel = SEL_RX;
        ctl.drReg  = 1'b1;
        ctl.ldB    = 1'b1;
        nextState  = S_M3;
      end
      S_M3: begin                  // MEM[MAR] <- A + B, Z <- (sum == 0)
        ctl.aluFn = ALU_ADD;
        ctl.drAlu = 1'b1;
        ctl.wrMem = 1'b1;
        ctl.ldZ   = 1'b1;
        nextState = S_F0;
      end
      default: nextState = S_HALT;
    endcase
  end

  assign halted = (state == S_HALT);

  AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldIr |-> $past(ctl.ldMar && ctl.ldA)); // R2
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && !ctl.ldPc && !ctl.wrMem)); // R7

endmodule

// File: rtl/sbusDatapath.sv
module sbusDatapath
  import sbusPkg::*;
#(
  parameter int WIDTH     = DATA_W,
  parameter int NREGS     = REG_CNT,
  parameter int DEPTH     = MEM_DEPTH,
  localparam int MEM_AW   = $clog2(DEPTH),
  localparam int REG_AW   = $clog2(NREGS),
  localparam int OFF_W    = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctl,
  input  logic              progWe,
  input  logic              progToReg,
  input  logic [MEM_AW-1:0] progAddr,
  input  logic [WIDTH-1:0]  progData,
  input  logic              peekToReg,
  input  logic [MEM_AW-1:0] peekAddr,
  output logic [WIDTH-1:0]  peekData,
  output logic [WIDTH-1:0]  pc,
  output logic              zFlag,
  output logic [3:0]        irOp
);

  logic [WIDTH-1:0]  pcQ, aQ, bQ, irQ;
  logic [MEM_AW-1:0] marQ;
  logic              zQ;
  logic [WIDTH-1:0]  busV, aluOut, regRd, regPeek, memRd, offExt;
  logic [REG_AW-1:0] selReg;
  logic [4:0]        drivers;

  // Instruction field decode
  always_comb begin
    case (ctl.regSel)
      SEL_RX:  selReg = irQ[27:24];
      SEL_RY:  selReg = irQ[23:20];
      SEL_RZ:  selReg = irQ[3:0];
      default: selReg = '0;
    endcase
  end
  assign offExt = {{(WIDTH-OFF_W){irQ[OFF_W-1]}}, irQ[OFF_W-1:0]};
  assign irOp   = irQ[WIDTH-1 -: 4];

  // Shared bus: each source gated by its drive strobe, then merged
  always_comb begin
    busV = '0;
    if (ctl.drPc)  busV = busV | pcQ;
    if (ctl.drAlu) busV = busV | aluOut;
    if (ctl.drReg) busV = busV | regRd;
    if (ctl.drMem) busV = busV | memRd;
    if (ctl.drOff) busV = busV | offExt;
  end
  assign drivers = {ctl.drPc, ctl.drAlu, ctl.drReg, ctl.drMem, ctl.drOff};

  sbusAlu #(.WIDTH(WIDTH)) uAlu (
    .fn(ctl.aluFn), .opA(aQ), .opB(bQ), .result(aluOut)
  );

  // Register file: preload only while reset is held
  logic              rfWe;
  logic [REG_AW-1:0] rfWAddr;
  logic [WIDTH-1:0]  rfWData;
  assign rfWe    = rstN ? ctl.wrReg : (progWe && progToReg);
  assign rfWAddr = rstN ? selReg : progAddr[REG_AW-1:0];
  assign rfWData = rstN ? busV : progData;

  sbusRegFile #(.WIDTH(WIDTH), .COUNT(NREGS)) uRegs (
    .clk(clk), .we(rfWe), .wAddr(rfWAddr), .wData(rfWData),
    .rAddr(selReg), .rData(regRd),
    .pAddr(peekAddr[REG_AW-1:0]), .pData(regPeek)
  );

  // Word memory, asynchronous read, indexed by MAR
  logic [WIDTH-1:0]  mem [DEPTH];
  logic              memWe;
  logic [MEM_AW-1:0] memWAddr;
  logic [WIDTH-1:0]  memWData;
  assign memWe    = rstN ? ctl.wrMem : (progWe && !progToReg);
  assign memWAddr = rstN ? marQ : progAddr;
  assign memWData = rstN ? busV : progData;

  always_ff @(posedge clk) begin
    if (memWe) mem[memWAddr] <= memWData;
  end
  assign memRd    = mem[marQ];
  assign peekData = peekToReg ? regPeek : mem[peekAddr];

  // Bus-loaded registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ  <= '0;
      aQ   <= '0;
      bQ   <= '0;
      irQ  <= '0;
      marQ <= '0;
      zQ   <= 1'b0;
    end else begin
      if (ctl.ldPc)  pcQ  <= busV;
      if (ctl.ldA)   aQ   <= busV;
      if (ctl.ldB)   bQ   <= busV;
      if (ctl.ldIr)  irQ  <= busV;
      if (ctl.ldMar) marQ <= busV[MEM_AW-1:0];
      if (ctl.ldZ)   zQ   <= (busV == '0);
    end
  end

  assign pc    = pcQ;
  assign zFlag = zQ;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(drivers)); // R9
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldPc |=> (pcQ == $past(pcQ) + WIDTH'(1))); // R2
  AST_WRITE_AFTER_B: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrMem |-> $past(ctl.ldB)); // R3
  AST_Z_MATCHES_MEM: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrMem |=> (zQ == (memRd == '0))); // R4

endmodule

// File: rtl/sbusCpu.sv
module sbusCpu
  import sbusPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        progWe,
  input  logic        progToReg,
  input  logic [9:0]  progAddr,
  input  logic [31:0] progData,
  input  logic        peekToReg,
  input  logic [9:0]  peekAddr,
  output logic [31:0] peekData,
  output logic [31:0] pc,
  output logic        zFlag,
  output logic        halted
);

  ctrlT       ctl;
  logic [3:0] irOp;

  sbusControl uCtrl (
    .clk(clk), .rstN(rstN), .opcode(irOp), .ctl(ctl), .halted(halted)
  );

  sbusDatapath #(.WIDTH(DATA_W), .NREGS(REG_CNT), .DEPTH(MEM_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .progWe(progWe), .progToReg(progToReg), .progAddr(progAddr),
    .progData(progData), .peekToReg(peekToReg), .peekAddr(peekAddr),
    .peekData(peekData), .pc(pc), .zFlag(zFlag), .irOp(irOp)
  );

endmodule

// File: tb/sbusCpu_bench.sv
`timescale 1ns/1ps
module sbusCpu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        progWe = 1'b0, progToReg = 1'b0, peekToReg = 1'b0;
  logic [9:0]  progAddr = '0, peekAddr = '0;
  logic [31:0] progData = '0;
  logic [31:0] peekData, pc;
  logic        zFlag, halted;

  always #4 clk = ~clk;   // 125 MHz

  sbusCpu u_sbusCpu (
    .clk(clk), .rstN(rstN), .progWe(progWe), .progToReg(progToReg),
    .progAddr(progAddr), .progData(progData), .peekToReg(peekToReg),
    .peekAddr(peekAddr), .peekData(peekData), .pc(pc), .zFlag(zFlag),
    .halted(halted)
  );

  int checks = 0, errors = 0;
  bit finished = 0, running = 0;

  // Behavioural reference state
  logic [31:0] mMem [1024];
  logic [31:0] mRegs [16];
  logic [31:0] mPc = 0, curIns = 0;
  logic        mZ = 0, mHalt = 0;
  int          step = 0;

  function automatic logic [31:0] rdReg(input logic [3:0] i);
    return (i == 0) ? 32'h0 : mRegs[i];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] addm(input logic [3:0] rx, input logic [3:0] ry);
    return {4'h5, rx, ry, 20'h0};
  endfunction

  task automatic preload(input bit toReg, input int addr, input logic [31:0] data);
    @(negedge clk);
    progWe = 1'b1; progToReg = toReg; progAddr = 10'(addr); progData = data;
    if (toReg) mRegs[addr] = data; else mMem[addr] = data;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  // Model: one step per rising edge, effects on their due edge
  always @(posedge clk) begin
    if (rstN && !mHalt) begin
      step++;
      if (step == 1) curIns = mMem[mPc[9:0]];
      if (step == 3) begin
        mPc = mPc + 1;
        if (curIns[31:28] == 4'hF) begin mHalt = 1; step = 0; end
        else if (curIns[31:28] != 4'h5) step = 0;
      end
      if (step == 7) begin
        logic [9:0]  a;
        logic [31:0] s;
        a = rdReg(curIns[23:20])[9:0];
        s = mMem[a] + rdReg(curIns[27:24]);
        mMem[a] = s;
        mZ = (s == 0);
        step = 0;
      end
    end
  end

  // Per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (running) begin
      chk("R2 pc", pc, mPc);
      chk("R7 halted", {31'h0, halted}, {31'h0, mHalt});
      chk("R4 zFlag", {31'h0, zFlag}, {31'h0, mZ});
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not halt");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) mRegs[i] = 0;
    @(negedge clk);
    chk("R1 reset pc", pc, 0);
    chk("R1 reset halted", {31'h0, halted}, 0);
    chk("R1 reset zFlag", {31'h0, zFlag}, 0);

    for (int i = 0; i < 1024; i++) preload(0, i, 32'h0);
    for (int i = 0; i < 16; i++) preload(1, i, 32'h0);
    preload(1, 0, 32'h1234);          // R5: ignored
    mRegs[0] = 32'h0;
    preload(1, 1, 32'd5);
    preload(1, 2, 32'd100);
    preload(1, 3, 32'h0000_0407);     // R6: upper bits set, targets word 7
    preload(1, 4, -32'sd50);
    preload(1, 5, 32'd200);
    preload(0, 100, 32'd10);
    preload(0, 7, 32'd3);
    preload(0, 200, 32'd50);
    preload(0, 300, 32'h0000_ABCD);
    preload(0, 0, addm(4'd1, 4'd2));  // word100 += 5
    preload(0, 1, 32'h0000_0000);     // opcode 0: no-op
    preload(0, 2, addm(4'd1, 4'd3));  // word7 += 5
    preload(0, 3, addm(4'd4, 4'd5));  // word200 += -50 -> 0, Z=1
    preload(0, 4, addm(4'd0, 4'd2));  // word100 += 0, Z=0
    preload(0, 5, 32'h3FFF_FFFF);     // opcode 3: no-op
    preload(0, 6, 32'hF000_0000);     // halt

    @(negedge clk);
    rstN = 1'b1;
    running = 1;

    // R10: preload strobe while running must not write
    repeat (10) @(negedge clk);
    progWe = 1'b1; progToReg = 1'b0; progAddr = 10'd300; progData = 32'hDEAD_0000;
    @(negedge clk);
    progWe = 1'b0;

    wait (mHalt);
    repeat (5) @(negedge clk);
    chk("R7 pc frozen after halt", pc, 32'd7);
    running = 0;

    peekToReg = 1'b0;
    peekAddr = 10'd100; #1 chk("R3 add result word100", peekData, 32'd15);
    // R9: a second bus source would merge into the sum and corrupt it
    peekAddr = 10'd7;   #1 chk("R6 low address bits word7", peekData, 32'd8);
    peekAddr = 10'd200; #1 chk("R4 zero sum word200", peekData, 32'd0);
    peekAddr = 10'd300; #1 chk("R10 running preload ignored", peekData, 32'h0000_ABCD);
    peekAddr = 10'd1;   #1 chk("R8 no-op left memory", peekData, 32'h0000_0000);
    peekAddr = 10'd5;   #1 chk("R8 no-op word intact", peekData, 32'h3FFF_FFFF);
    for (int i = 0; i < 1024; i++) begin
      peekAddr = 10'(i); #1;
      if (peekData !== mMem[i]) chk("R3 memory image", peekData, mMem[i]);
    end
    peekToReg = 1'b1;
    peekAddr = 10'd0; #1 chk("R5 reg0 reads zero", peekData, 32'h0);
    peekAddr = 10'd1; #1 chk("R5 reg1 intact", peekData, 32'd5);
    peekAddr = 10'd3; #1 chk("R6 reg3 intact", peekData, 32'h0000_0407);
    summary();
  end

endmodule